// File: doc/BRIEF.md
# Load-use interlock stall scoreboard

The block sits beside the issue stage of a pipelined core and remembers, for every architectural register, the absolute cycle at which the result of a pending load may first be consumed. A free-running 64-bit cycle timestamp lives inside the block. When a load retires its timing, the writeback port reports the kind of load, the destination register (or a register list for a block load), the two low address bits, whether the destination is the program counter, whether the access aborted, and how many cycles the issuing instruction itself took. The block then records a ready time of latency plus current timestamp plus instruction cycles for the one register that the load kind designates.

The query port takes one or two source register indices from a consuming instruction and returns, in the same cycle, the number of stall cycles that instruction must wait. The wait is the larger of the two per-register waits, saturated to the output width, together with the multiply/normal type tag of the register that sets it. When the issue stage marks a query as taken, the reported stall is added to the timestamp so that the stall is charged to time.

Top module: `ldu_scoreboard`

## Requirements
- R1: Reset clears every ready time and type tag; after reset every query returns stall 0 and type 0, even for a register armed before the reset.
- R2: A word load (kind code 0) gives latency 1 when addr_lo is 0 and latency 2 otherwise; a query on its register in the cycle after the writeback returns cycles plus latency minus 1.
- R3: Byte (code 1), halfword (code 2), signed byte (code 3) and signed halfword (code 4) loads always give latency 2, whatever the address bits.
- R4: A doubleword load (code 5) arms only the register one above the even register given, with latency 1; the given register is left untouched, and an odd given register arms nothing.
- R5: A block load (code 6) arms only the highest-numbered register set in the list, with latency 1; lower registers in the list are untouched, and a list that contains register 15 arms nothing.
- R6: A swap (code 7) arms its destination with latency 1.
- R7: A writeback with the PC-destination flag set, or whose resolved register is 15, writes no entry; an earlier entry for that register keeps its wait.
- R8: A writeback with the abort flag set writes no entry; an earlier entry for that register keeps its wait.
- R9: With two sources enabled the stall is the larger of the two waits; with one source the second index has no effect.
- R10: A register's wait is its ready time minus the current timestamp when positive and 0 otherwise, so without new writes or taken queries it falls by one per cycle and then stays at 0.
- R11: The timestamp advances by one per clock plus the reported stall in a cycle where q_valid is high, so a register whose stall was taken reports 0 on the next cycle.
- R12: q_type gives the type tag written with the entry of the source that sets the stall (1 for a multiply, 0 for a normal load), and 0 when the stall is 0.
- R13: A wait larger than the output can hold reports the all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | 1 | Load timing writeback present this cycle |
| wb_kind | input | 3 | Load kind code (0 word, 1 byte, 2 half, 3 signed byte, 4 signed half, 5 doubleword, 6 block, 7 swap) |
| wb_reg | input | 4 | Destination register (first register of a doubleword) |
| wb_list | input | 16 | Register list of a block load |
| wb_addr_lo | input | 2 | Two low address bits of the access |
| wb_pc_dest | input | 1 | Destination is the program counter |
| wb_abort | input | 1 | Access aborted (or swap read/write failed) |
| wb_cycles | input | 8 | Cycles taken by the issuing instruction |
| wb_mul | input | 1 | Type tag to store: 1 multiply, 0 normal load |
| q_valid | input | 1 | Issue stage takes the reported stall this cycle |
| q_src_a | input | 4 | First source register |
| q_src_b | input | 4 | Second source register |
| q_two | input | 1 | Second source is in use |
| q_stall | output | 8 | Stall cycles the consumer must wait |
| q_type | output | 1 | Type tag of the register setting the stall |

## Verification
Every load kind is written with chosen instruction cycle counts and address bits and probed in the following cycle, which separates the latency-1 and latency-2 cases and shows which register of a doubleword or block load carries the interlock. Probes of the other registers named by the same load show that they stay free, and abort or PC-destination writebacks laid over a live entry show that the old wait survives rather than being cleared or replaced. A long-lived entry is watched as it decays cycle by cycle and compared against the same entry with its stall taken, which tells the plain clock advance apart from the stall charge, while two-source queries in both orders with and without the second source enabled tell the maximum apart from a fixed pick.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
   typedef enum logic [2:0] {
      LK_WORD   = 3'd0,
      LK_BYTE   = 3'd1,
      LK_HALF   = 3'd2,
      LK_SBYTE  = 3'd3,
      LK_SHALF  = 3'd4,
      LK_DOUBLE = 3'd5,
      LK_BLOCK  = 3'd6,
      LK_SWAP   = 3'd7
   } ld_kind_e;

   localparam int unsigned LAT_W = 2;
endpackage

// File: rtl/ldu_latency.sv
module ldu_latency
   import ldu_pkg::*;
#(
   parameter int unsigned NREG  = 16,
   parameter int unsigned REG_W = $clog2(NREG)
) (
   input  logic             valid,
   input  logic [2:0]       kind,
   input  logic [REG_W-1:0] reg_in,
   input  logic [NREG-1:0]  list,
   input  logic [1:0]       addr_lo,
   input  logic             pc_dest,
   input  logic             abort,
   output logic             arm,
   output logic [REG_W-1:0] idx,
   output logic [LAT_W-1:0] lat
);
   localparam logic [REG_W-1:0] PC_IDX = REG_W'(NREG - 1);

   logic     arm_kind;
   ld_kind_e k;

   assign k = ld_kind_e'(kind);

   always_comb begin
      arm_kind = 1'b1;
      idx      = reg_in;
      lat      = LAT_W'(2);
      unique case (k)
         LK_WORD: lat = (addr_lo != 2'b00) ? LAT_W'(2) : LAT_W'(1);
         LK_BYTE, LK_HALF, LK_SBYTE, LK_SHALF: lat = LAT_W'(2);
         LK_DOUBLE: begin
            lat = LAT_W'(1);
            idx = reg_in + REG_W'(1);
            if (reg_in[0]) arm_kind = 1'b0;
         end
         LK_BLOCK: begin
            lat = LAT_W'(1);
            for (int i = 0; i < NREG; i++) begin
               if (list[i]) idx = REG_W'(i);
            end
            if (list == '0 || list[NREG-1]) arm_kind = 1'b0;
         end
         LK_SWAP: lat = LAT_W'(1);
         default: arm_kind = 1'b0;
      endcase
   end

   assign arm = valid && arm_kind && !abort && !pc_dest && (idx != PC_IDX);

   // R7: the program-counter entry is never armed
   always_comb begin
      if (arm) a_r7_never_pc: assert (idx != PC_IDX);
   end
endmodule

// File: rtl/ldu_entry_bank.sv
module ldu_entry_bank #(
   parameter int unsigned NREG  = 16,
   parameter int unsigned REG_W = $clog2(NREG),
   parameter int unsigned TS_W  = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [REG_W-1:0]     widx,
   input  logic [TS_W-1:0]      wready,
   input  logic                 wtag,
   output logic [NREG*TS_W-1:0] ready_flat,
   output logic [NREG-1:0]      tag_vec
);
   for (genvar r = 0; r < NREG; r++) begin : g_ent
      logic [TS_W-1:0] ready_q;
      logic            tag_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ready_q <= '0;
            tag_q   <= 1'b0;
         end else if (we && widx == REG_W'(r)) begin
            ready_q <= wready;
            tag_q   <= wtag;
         end
      end

      assign ready_flat[r*TS_W +: TS_W] = ready_q;
      assign tag_vec[r]                 = tag_q;
   end
endmodule

// File: rtl/ldu_wait_sel.sv
module ldu_wait_sel #(
   parameter int unsigned NREG    = 16,
   parameter int unsigned REG_W   = $clog2(NREG),
   parameter int unsigned TS_W    = 64,
   parameter int unsigned STALL_W = 8
) (
   input  logic [NREG*TS_W-1:0] ready_flat,
   input  logic [NREG-1:0]      tag_vec,
   input  logic [TS_W-1:0]      ts,
   input  logic [REG_W-1:0]     src_a,
   input  logic [REG_W-1:0]     src_b,
   input  logic                 two,
   output logic [STALL_W-1:0]   wait_a,
   output logic [STALL_W-1:0]   wait_b,
   output logic [STALL_W-1:0]   stall,
   output logic                 tag
);
   logic [REG_W-1:0]   src [2];
   logic [STALL_W-1:0] w   [2];
   logic               tg  [2];
   logic               pick_b;

   assign src[0] = src_a;
   assign src[1] = src_b;

   for (genvar s = 0; s < 2; s++) begin : g_src
      logic [TS_W-1:0] rdy;
      logic [TS_W-1:0] raw;

      assign rdy   = ready_flat[src[s]*TS_W +: TS_W];
      assign raw   = (rdy > ts) ? (rdy - ts) : '0;
      assign tg[s] = tag_vec[src[s]];

      if (STALL_W < TS_W) begin : g_sat
         assign w[s] = (|raw[TS_W-1:STALL_W]) ? '1 : raw[STALL_W-1:0];
      end else begin : g_full
         assign w[s] = raw;
      end
   end

   assign wait_a = w[0];
   assign wait_b = w[1];
   assign pick_b = two && (w[1] > w[0]);
   assign stall  = pick_b ? w[1] : w[0];
   assign tag    = (stall == '0) ? 1'b0 : (pick_b ? tg[1] : tg[0]);
endmodule

// File: rtl/ldu_scoreboard.sv
module ldu_scoreboard
   import ldu_pkg::*;
#(
   parameter int unsigned NREG    = 16,
   parameter int unsigned TS_W    = 64,
   parameter int unsigned CYC_W   = 8,
   parameter int unsigned STALL_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wb_valid,
   input  logic [2:0]             wb_kind,
   input  logic [$clog2(NREG)-1:0] wb_reg,
   input  logic [NREG-1:0]        wb_list,
   input  logic [1:0]             wb_addr_lo,
   input  logic                   wb_pc_dest,
   input  logic                   wb_abort,
   input  logic [CYC_W-1:0]       wb_cycles,
   input  logic                   wb_mul,
   input  logic                   q_valid,
   input  logic [$clog2(NREG)-1:0] q_src_a,
   input  logic [$clog2(NREG)-1:0] q_src_b,
   input  logic                   q_two,
   output logic [STALL_W-1:0]     q_stall,
   output logic                   q_type
);
   localparam int unsigned REG_W = $clog2(NREG);

   if (NREG < 2 || (1 << REG_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (STALL_W > TS_W || CYC_W >= TS_W) begin : g_bad_width
      $error("STALL_W and CYC_W must fit inside TS_W");
   end

   logic [TS_W-1:0]      ts_q;
   logic                 arm;
   logic [REG_W-1:0]     widx;
   logic [LAT_W-1:0]     lat;
   logic [TS_W-1:0]      wready;
   logic [NREG*TS_W-1:0] ready_flat;
   logic [NREG-1:0]      tag_vec;
   logic [STALL_W-1:0]   wait_a;
   logic [STALL_W-1:0]   wait_b;

   always_ff @(posedge clk) begin
      if (!rst_n) ts_q <= '0;
      else        ts_q <= ts_q + TS_W'(1) + (q_valid ? TS_W'(q_stall) : '0);
   end

   ldu_latency #(.NREG(NREG), .REG_W(REG_W)) i_latency (
      .valid   (wb_valid),
      .kind    (wb_kind),
      .reg_in  (wb_reg),
      .list    (wb_list),
      .addr_lo (wb_addr_lo),
      .pc_dest (wb_pc_dest),
      .abort   (wb_abort),
      .arm     (arm),
      .idx     (widx),
      .lat     (lat)
   );

   assign wready = ts_q + TS_W'(wb_cycles) + TS_W'(lat);

   ldu_entry_bank #(.NREG(NREG), .REG_W(REG_W), .TS_W(TS_W)) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (arm),
      .widx       (widx),
      .wready     (wready),
      .wtag       (wb_mul),
      .ready_flat (ready_flat),
      .tag_vec    (tag_vec)
   );

   ldu_wait_sel #(.NREG(NREG), .REG_W(REG_W), .TS_W(TS_W), .STALL_W(STALL_W)) i_sel (
      .ready_flat (ready_flat),
      .tag_vec    (tag_vec),
      .ts         (ts_q),
      .src_a      (q_src_a),
      .src_b      (q_src_b),
      .two        (q_two),
      .wait_a     (wait_a),
      .wait_b     (wait_b),
      .stall      (q_stall),
      .tag        (q_type)
   );

   // R10: an untouched entry decays by one per plain clock
   a_r10_stall_decay: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wb_valid) && !$past(q_valid) && !q_two && !$past(q_two) &&
       $stable(q_src_a) && $past(q_stall) != '0 && $past(q_stall) != '1)
      |-> q_stall == $past(q_stall) - STALL_W'(1));

   // R11: a taken stall is fully charged to the timestamp
   a_r11_query_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wb_valid) && $past(q_valid) && !q_two && !$past(q_two) &&
       $stable(q_src_a) && $past(q_stall) != '1)
      |-> q_stall == '0);

   // R7: a PC-destination writeback leaves every entry as it was
   a_r7_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_pc_dest) |=> $stable(ready_flat));

   // R8: an aborted writeback leaves every entry as it was
   a_r8_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_abort) |=> $stable(ready_flat));

   // R9: the stall covers every enabled source and equals one of them
   a_r9_max_cover: assert property (@(posedge clk) disable iff (!rst_n)
      (q_stall >= wait_a) && (!q_two || q_stall >= wait_b) &&
      (q_stall == wait_a || (q_two && q_stall == wait_b)));
endmodule

// File: tb/test_ldu_scoreboard.sv
`timescale 1ns/1ps
module test_ldu_scoreboard;
   localparam int NV = 21;

   typedef struct packed {
      logic [2:0]  kind;
      logic [3:0]  rg;
      logic [15:0] list;
      logic [1:0]  alo;
      logic        pc;
      logic        ab;
      logic [7:0]  cyc;
      logic        mul;
      logic [3:0]  probe;
      logic [7:0]  exp_stall;
      logic        exp_type;
      logic [15:0] tag;
   } vec_t;

   // expected stall = cycles + latency - 1 in the cycle after the writeback
   localparam vec_t VECS [NV] = '{
      '{3'd0, 4'd1,  16'h0000, 2'd0, 1'b0, 1'b0, 8'd1,   1'b0, 4'd1,  8'd1,   1'b0, "R2"},
      '{3'd0, 4'd2,  16'h0000, 2'd2, 1'b0, 1'b0, 8'd1,   1'b0, 4'd2,  8'd2,   1'b0, "R2"},
      '{3'd0, 4'd2,  16'h0000, 2'd1, 1'b0, 1'b0, 8'd3,   1'b0, 4'd2,  8'd4,   1'b0, "R2"},
      '{3'd1, 4'd3,  16'h0000, 2'd0, 1'b0, 1'b0, 8'd2,   1'b0, 4'd3,  8'd3,   1'b0, "R3"},
      '{3'd2, 4'd4,  16'h0000, 2'd0, 1'b0, 1'b0, 8'd1,   1'b0, 4'd4,  8'd2,   1'b0, "R3"},
      '{3'd3, 4'd5,  16'h0000, 2'd3, 1'b0, 1'b0, 8'd1,   1'b0, 4'd5,  8'd2,   1'b0, "R3"},
      '{3'd4, 4'd6,  16'h0000, 2'd0, 1'b0, 1'b0, 8'd4,   1'b0, 4'd6,  8'd5,   1'b0, "R3"},
      '{3'd5, 4'd8,  16'h0000, 2'd0, 1'b0, 1'b0, 8'd2,   1'b0, 4'd9,  8'd2,   1'b0, "R4"},
      '{3'd5, 4'd8,  16'h0000, 2'd0, 1'b0, 1'b0, 8'd2,   1'b0, 4'd8,  8'd0,   1'b0, "R4"},
      '{3'd5, 4'd9,  16'h0000, 2'd0, 1'b0, 1'b0, 8'd2,   1'b0, 4'd10, 8'd0,   1'b0, "R4"},
      '{3'd5, 4'd14, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd2,   1'b0, 4'd15, 8'd0,   1'b0, "R7"},
      '{3'd6, 4'd0,  16'h00F0, 2'd0, 1'b0, 1'b0, 8'd5,   1'b0, 4'd7,  8'd5,   1'b0, "R5"},
      '{3'd6, 4'd0,  16'h00F0, 2'd0, 1'b0, 1'b0, 8'd5,   1'b0, 4'd4,  8'd0,   1'b0, "R5"},
      '{3'd6, 4'd0,  16'h0006, 2'd0, 1'b0, 1'b0, 8'd1,   1'b0, 4'd2,  8'd1,   1'b0, "R5"},
      '{3'd6, 4'd0,  16'h8003, 2'd0, 1'b0, 1'b0, 8'd3,   1'b0, 4'd1,  8'd0,   1'b0, "R5"},
      '{3'd7, 4'd10, 16'h0000, 2'd1, 1'b0, 1'b0, 8'd3,   1'b0, 4'd10, 8'd3,   1'b0, "R6"},
      '{3'd7, 4'd10, 16'h0000, 2'd0, 1'b0, 1'b1, 8'd3,   1'b0, 4'd10, 8'd0,   1'b0, "R8"},
      '{3'd0, 4'd11, 16'h0000, 2'd0, 1'b1, 1'b0, 8'd2,   1'b0, 4'd11, 8'd0,   1'b0, "R7"},
      '{3'd0, 4'd15, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd2,   1'b0, 4'd15, 8'd0,   1'b0, "R7"},
      '{3'd0, 4'd12, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd2,   1'b1, 4'd12, 8'd2,   1'b1, "R12"},
      '{3'd1, 4'd13, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd255, 1'b0, 4'd13, 8'd255, 1'b0, "R13"}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wb_valid = 1'b0;
   logic [2:0]  wb_kind = '0;
   logic [3:0]  wb_reg = '0;
   logic [15:0] wb_list = '0;
   logic [1:0]  wb_addr_lo = '0;
   logic        wb_pc_dest = 1'b0;
   logic        wb_abort = 1'b0;
   logic [7:0]  wb_cycles = '0;
   logic        wb_mul = 1'b0;
   logic        q_valid = 1'b0;
   logic [3:0]  q_src_a = '0;
   logic [3:0]  q_src_b = '0;
   logic        q_two = 1'b0;
   logic [7:0]  q_stall;
   logic        q_type;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ldu_scoreboard i_ldu_scoreboard (
      .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_kind(wb_kind),
      .wb_reg(wb_reg), .wb_list(wb_list), .wb_addr_lo(wb_addr_lo),
      .wb_pc_dest(wb_pc_dest), .wb_abort(wb_abort), .wb_cycles(wb_cycles),
      .wb_mul(wb_mul), .q_valid(q_valid), .q_src_a(q_src_a), .q_src_b(q_src_b),
      .q_two(q_two), .q_stall(q_stall), .q_type(q_type)
   );

   task automatic chk(input string tg, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tg, what, act, exp);
      end
   endtask

   task automatic wb_set(input logic [2:0] k, input logic [3:0] r, input logic [15:0] l,
                         input logic [1:0] a, input logic pc, input logic ab,
                         input logic [7:0] c, input logic m);
      wb_valid = 1'b1; wb_kind = k; wb_reg = r; wb_list = l; wb_addr_lo = a;
      wb_pc_dest = pc; wb_abort = ab; wb_cycles = c; wb_mul = m;
   endtask

   task automatic wb_clear();
      wb_valid = 1'b0; wb_pc_dest = 1'b0; wb_abort = 1'b0; wb_mul = 1'b0;
   endtask

   task automatic probe(input logic [3:0] a);
      q_src_a = a; q_two = 1'b0; #1;
   endtask

   task automatic flush();
      q_valid = 1'b0;
      repeat (300) @(negedge clk);
   endtask

   initial begin
      #(8ns * 150000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: everything reads zero after reset
      for (int r = 0; r < 16; r += 5) begin
         probe(4'(r));
         chk("R1", "reset stall", int'(q_stall), 0);
         chk("R1", "reset type", int'(q_type), 0);
      end

      // table walk
      for (int v = 0; v < NV; v++) begin
         flush();
         wb_set(VECS[v].kind, VECS[v].rg, VECS[v].list, VECS[v].alo,
                VECS[v].pc, VECS[v].ab, VECS[v].cyc, VECS[v].mul);
         @(negedge clk);
         wb_clear();
         probe(VECS[v].probe);
         chk($sformatf("%s", VECS[v].tag), $sformatf("vector %0d stall", v),
             int'(q_stall), int'(VECS[v].exp_stall));
         chk($sformatf("%s", VECS[v].tag), $sformatf("vector %0d type", v),
             int'(q_type), int'(VECS[v].exp_type));
      end

      // R10: decay of a word load with 4 instruction cycles (ready = T+5)
      flush();
      wb_set(3'd0, 4'd3, 16'h0, 2'd0, 1'b0, 1'b0, 8'd4, 1'b0);
      @(negedge clk); wb_clear(); probe(4'd3);
      chk("R10", "decay start", int'(q_stall), 4);
      repeat (2) @(negedge clk); #1;
      chk("R10", "decay after 2", int'(q_stall), 2);
      repeat (3) @(negedge clk); #1;
      chk("R10", "decay floor", int'(q_stall), 0);
      repeat (2) @(negedge clk); #1;
      chk("R10", "decay stays zero", int'(q_stall), 0);

      // R11: taking the stall moves time past the ready point
      flush();
      wb_set(3'd0, 4'd7, 16'h0, 2'd0, 1'b0, 1'b0, 8'd6, 1'b0);
      @(negedge clk); wb_clear(); q_valid = 1'b1; probe(4'd7);
      chk("R11", "stall before take", int'(q_stall), 6);
      @(negedge clk); q_valid = 1'b0; #1;
      chk("R11", "stall after take", int'(q_stall), 0);

      // R9 / R12: r1 ready in 1, r2 (multiply tag) ready in 6
      flush();
      wb_set(3'd0, 4'd1, 16'h0, 2'd0, 1'b0, 1'b0, 8'd2, 1'b0);
      @(negedge clk);
      wb_set(3'd1, 4'd2, 16'h0, 2'd0, 1'b0, 1'b0, 8'd5, 1'b1);
      @(negedge clk); wb_clear();
      q_src_a = 4'd1; q_src_b = 4'd2; q_two = 1'b1; #1;
      chk("R9", "max a<b", int'(q_stall), 6);
      chk("R12", "type from b", int'(q_type), 1);
      q_two = 1'b0; #1;
      chk("R9", "b ignored", int'(q_stall), 1);
      chk("R12", "type from a", int'(q_type), 0);
      q_src_a = 4'd2; q_src_b = 4'd1; q_two = 1'b1; #1;
      chk("R9", "max a>b", int'(q_stall), 6);
      q_two = 1'b0;

      // R8: abort over a live entry keeps the old wait
      flush();
      wb_set(3'd0, 4'd6, 16'h0, 2'd0, 1'b0, 1'b0, 8'd20, 1'b0);
      @(negedge clk);
      wb_set(3'd0, 4'd6, 16'h0, 2'd0, 1'b0, 1'b1, 8'd1, 1'b0);
      probe(4'd6);
      chk("R8", "live entry", int'(q_stall), 20);
      @(negedge clk); wb_clear(); #1;
      chk("R8", "entry kept after abort", int'(q_stall), 19);

      // R7: PC-destination flag over a live entry keeps the old wait
      flush();
      wb_set(3'd0, 4'd5, 16'h0, 2'd0, 1'b0, 1'b0, 8'd20, 1'b0);
      @(negedge clk);
      wb_set(3'd0, 4'd5, 16'h0, 2'd0, 1'b1, 1'b0, 8'd1, 1'b0);
      @(negedge clk); wb_clear(); probe(4'd5);
      chk("R7", "entry kept after PC dest", int'(q_stall), 19);

      // R1: reset in the middle clears an armed entry
      flush();
      wb_set(3'd0, 4'd4, 16'h0, 2'd0, 1'b0, 1'b0, 8'd10, 1'b1);
      @(negedge clk); wb_clear(); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; probe(4'd4);
      chk("R1", "armed entry cleared", int'(q_stall), 0);
      chk("R1", "armed tag cleared", int'(q_type), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule